// File: doc/BRIEF.md
# Register Bank with On-Chip Context Slots

This block is the general-purpose register file of a 32-bit processor: 32 words of 32 bits, two combinational read ports and one write port. Register 0 always reads as zero. The block also holds a small store of context slots. A thread's working set of registers and its program counter can be copied into a slot, or copied back out of one, with a single command. This replaces one memory access per register.

The command is two bits wide. Save is `01` and restore is `11`. The caller does not give the slot number directly. It names a general register, and the low bits of that register's value select the slot. The working set is always the same twelve words: the temporaries r8–r15 and r24, the global pointer r28, the stack pointer r29, and the program counter. The program counter enters on `pc_in` and leaves on `pc_out`. Every operation takes exactly four cycles. While it runs, `busy` is high, and `done` pulses in the last of those cycles.

Top module: `ctx_regbank`

## Requirements
- R1: Register 0 reads as zero on both read ports, and any write to address 0 is discarded.
- R2: Both read ports return the addressed register combinationally. The write port updates the addressed register at the clock edge when `wr_en` is high and `busy` is low.
- R3: Command `01` (save) presented while `busy` is low is accepted at the next edge. `busy` is then high for exactly 4 cycles and `done` is high only in the fourth of them.
- R4: A save copies r8–r15, r24, r28, r29 and the value on `pc_in`, all as they are in the accepting cycle, into the slot whose number is the low 2 bits of the register that `ctx_idx_reg` names. Later changes to those registers or to `pc_in` do not alter the saved copy.
- R5: Command `11` (restore) writes the 11 saved registers back into the bank and the saved program counter onto `pc_out`. All 12 are visible by the cycle in which `done` is high. Registers outside the working set are left unchanged.
- R6: Restore uses the same 4-cycle `busy` window, with `done` in the fourth cycle, as save.
- R7: Commands `00` (idle) and `10` (reserved) start no operation and change no state.
- R8: While `busy` is high, new commands and write-port writes are ignored, and reads keep returning the current bank contents.
- R9: After reset every slot holds zeros, so a restore from a slot that was never saved loads zeros into the working set and onto `pc_out`.
- R10: The slot number is captured when the command is accepted. A write that changes the index register in that same cycle does not redirect the operation.
- R11: After reset `busy`, `done` and `pc_out` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 5 | Write port address |
| wr_data | input | 32 | Write port data |
| ctx_cmd | input | 2 | 00 idle, 01 save, 10 reserved, 11 restore |
| ctx_idx_reg | input | 5 | Register whose value selects the slot |
| pc_in | input | 32 | Program counter to be saved |
| pc_out | output | 32 | Program counter loaded by a restore |
| busy | output | 1 | A context operation is in progress |
| done | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
The checker assumes that `ctx_cmd` is known in every cycle after reset. It also assumes that a command is meant to be held for only one cycle when `busy` is low. The bench therefore drives a command for exactly one edge and then returns it to idle. It raises commands during busy windows only to show that they are dropped. The `pc_out` property expects the program counter output to move only in a done cycle. This holds because the bench never resets the block in the middle of an operation.

// File: rtl/ctxbank_pkg.sv
package ctxbank_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_CNT   = 32;
    localparam int SLOT_CNT  = 4;
    localparam int CTX_WORDS = 12;
    localparam int CTX_GPRS  = CTX_WORDS - 1;
    localparam int OP_CYCLES = 4;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_SAVE = 2'b01,
        CMD_RSVD = 2'b10,
        CMD_LOAD = 2'b11
    } ctx_cmd_e;

    typedef struct packed {
        logic       busy;
        logic       load;
        logic [1:0] phase;
    } seq_state_t;

    // Bank address of working-set entry k (the last entry is the PC, not a register)
    function automatic logic [4:0] ctx_gpr_addr(input int k);
        if (k < 8)       return 5'(8 + k);
        else if (k == 8) return 5'd24;
        else if (k == 9) return 5'd29;
        else             return 5'd28;
    endfunction

endpackage

// File: rtl/ctx_gpr_file.sv
module ctx_gpr_file
    import ctxbank_pkg::*;
#(
    parameter int XLEN  = DATA_W,
    parameter int NREGS = REG_CNT,
    parameter int NCTX  = CTX_GPRS,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra_a,
    output logic [XLEN-1:0] rd_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_b,
    input  logic [AW-1:0]   ra_c,
    output logic [XLEN-1:0] rd_c,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    input  logic            ld_en,
    input  logic [XLEN-1:0] ld_words [NCTX],
    output logic [XLEN-1:0] snap     [NCTX]
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else begin
            if (we && wa != '0) regs[wa] <= wd;
            if (ld_en) begin
                for (int k = 0; k < NCTX; k++) regs[AW'(ctx_gpr_addr(k))] <= ld_words[k];
            end
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];

    for (genvar k = 0; k < NCTX; k++) begin : g_snap
        assign snap[k] = regs[AW'(ctx_gpr_addr(k))];
    end

endmodule

// File: rtl/ctx_slot_store.sv
module ctx_slot_store
    import ctxbank_pkg::*;
#(
    parameter int XLEN   = DATA_W,
    parameter int NSLOTS = SLOT_CNT,
    parameter int NWORDS = CTX_WORDS,
    localparam int SW    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_sel,
    input  logic [XLEN-1:0] wr_words [NWORDS],
    input  logic [SW-1:0]   rd_sel,
    output logic [XLEN-1:0] rd_words [NWORDS]
);

    logic [XLEN-1:0] mem [NSLOTS][NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOTS; s++)
                for (int w = 0; w < NWORDS; w++) mem[s][w] <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NWORDS; w++) mem[wr_sel][w] <= wr_words[w];
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_rd
        assign rd_words[w] = mem[rd_sel][w];
    end

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctxbank_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int NCYC   = OP_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [SLOT_W-1:0] slot_in,
    output logic              busy,
    output logic              done,
    output logic              save_fire,
    output logic              load_fire,
    output logic [SLOT_W-1:0] slot_q
);

    localparam logic [1:0] LAST_PH = 2'(NCYC - 1);
    localparam logic [1:0] LOAD_PH = 2'(NCYC - 2);

    seq_state_t st;
    logic       accept;

    assign accept    = !st.busy && (cmd == CMD_SAVE || cmd == CMD_LOAD);
    assign save_fire = accept && (cmd == CMD_SAVE);
    assign load_fire = st.busy && st.load && (st.phase == LOAD_PH);
    assign done      = st.busy && (st.phase == LAST_PH);
    assign busy      = st.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            slot_q <= '0;
        end else if (accept) begin
            st.busy  <= 1'b1;
            st.load  <= (cmd == CMD_LOAD);
            st.phase <= '0;
            slot_q   <= slot_in;
        end else if (st.busy) begin
            st.phase <= st.phase + 2'd1;
            if (st.phase == LAST_PH) st.busy <= 1'b0;
        end
    end

endmodule

// File: rtl/ctx_regbank.sv
module ctx_regbank
    import ctxbank_pkg::*;
#(
    parameter int XLEN   = DATA_W,
    parameter int NREGS  = REG_CNT,
    parameter int NSLOTS = SLOT_CNT,
    localparam int AW    = $clog2(NREGS),
    localparam int SW    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [1:0]      ctx_cmd,
    input  logic [AW-1:0]   ctx_idx_reg,
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] pc_out,
    output logic            busy,
    output logic            done
);

    localparam int PC_SLOT = CTX_WORDS - 1;

    logic [XLEN-1:0] idx_val;
    logic            idx_unused;
    logic [XLEN-1:0] snap      [CTX_GPRS];
    logic [XLEN-1:0] ld_words  [CTX_GPRS];
    logic [XLEN-1:0] slot_wr   [CTX_WORDS];
    logic [XLEN-1:0] slot_rd   [CTX_WORDS];
    logic            save_fire;
    logic            load_fire;
    logic [SW-1:0]   slot_q;

    assign idx_unused = ^idx_val[XLEN-1:SW];

    ctx_seq #(.SLOT_W(SW), .NCYC(OP_CYCLES)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .cmd       (ctx_cmd),
        .slot_in   (idx_val[SW-1:0]),
        .busy      (busy),
        .done      (done),
        .save_fire (save_fire),
        .load_fire (load_fire),
        .slot_q    (slot_q)
    );

    ctx_gpr_file #(.XLEN(XLEN), .NREGS(NREGS), .NCTX(CTX_GPRS)) gpr_i (
        .clk      (clk),
        .rst      (rst),
        .ra_a     (rd_addr_a),
        .rd_a     (rd_data_a),
        .ra_b     (rd_addr_b),
        .rd_b     (rd_data_b),
        .ra_c     (ctx_idx_reg),
        .rd_c     (idx_val),
        .we       (wr_en && !busy),
        .wa       (wr_addr),
        .wd       (wr_data),
        .ld_en    (load_fire),
        .ld_words (ld_words),
        .snap     (snap)
    );

    for (genvar k = 0; k < CTX_GPRS; k++) begin : g_map
        assign slot_wr[k]  = snap[k];
        assign ld_words[k] = slot_rd[k];
    end
    assign slot_wr[PC_SLOT] = pc_in;

    ctx_slot_store #(.XLEN(XLEN), .NSLOTS(NSLOTS), .NWORDS(CTX_WORDS)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (save_fire),
        .wr_sel   (idx_val[SW-1:0]),
        .wr_words (slot_wr),
        .rd_sel   (slot_q),
        .rd_words (slot_rd)
    );

    always_ff @(posedge clk) begin
        if (rst)            pc_out <= '0;
        else if (load_fire) pc_out <= slot_rd[PC_SLOT];
    end

endmodule

// File: rtl/ctx_regbank_chk.sv
module ctx_regbank_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   rd_addr_a,
    input logic [XLEN-1:0] rd_data_a,
    input logic [AW-1:0]   rd_addr_b,
    input logic [XLEN-1:0] rd_data_b,
    input logic [1:0]      ctx_cmd,
    input logic [XLEN-1:0] pc_out,
    input logic            busy,
    input logic            done
);

    // R1
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    // R1
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    // R3
    cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctx_cmd[0]) |=> busy);

    // R6
    done_at_fourth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ##3 done);

    // R3
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R3
    done_ends_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    // R7
    idle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctx_cmd[0]) |=> !busy);

    // R5
    pc_moves_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_out) |-> done);

endmodule

bind ctx_regbank ctx_regbank_chk #(.XLEN(XLEN), .AW(AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .ctx_cmd   (ctx_cmd),
    .pc_out    (pc_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/ctx_regbank_tb_top.sv
`timescale 1ns/1ps
module ctx_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ctx_cmd = 2'b00;
    logic [4:0]  ctx_idx_reg = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] pc_out;
    logic        busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ctx_regbank dut_i (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctx_cmd(ctx_cmd), .ctx_idx_reg(ctx_idx_reg),
        .pc_in(pc_in), .pc_out(pc_out), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd3,  32'h1234_5678, 32'h1234_5678},
        '{5'd0,  32'hFFFF_FFFF, 32'h0000_0000},
        '{5'd31, 32'h8000_0001, 32'h8000_0001},
        '{5'd8,  32'hCAFE_F00D, 32'hCAFE_F00D},
        '{5'd3,  32'h0BAD_BEEF, 32'h0BAD_BEEF},
        '{5'd17, 32'h0000_0000, 32'h0000_0000},
        '{5'd0,  32'h0000_0001, 32'h0000_0000},
        '{5'd24, 32'h55AA_55AA, 32'h55AA_55AA}
    };

    // Working set: r8..r15, r24, r29 (stack pointer), r28 (global pointer)
    function automatic logic [4:0] ws_reg(input int k);
        if (k < 8)       return 5'(8 + k);
        else if (k == 8) return 5'd24;
        else if (k == 9) return 5'd29;
        else             return 5'd28;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] base, input int k);
        return base ^ (32'h0101_0101 * (k + 1));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic read_a(input logic [4:0] a, output logic [31:0] d);
        rd_addr_a = a; #0.5;
        d = rd_data_a;
    endtask

    task automatic fill_ws(input logic [31:0] base);
        for (int k = 0; k < 11; k++) wr_reg(ws_reg(k), pat(base, k));
    endtask

    task automatic check_ws(input string req, input logic [31:0] base, input bit zero);
        logic [31:0] d;
        for (int k = 0; k < 11; k++) begin
            read_a(ws_reg(k), d);
            check(req, d, zero ? 32'h0 : pat(base, k));
        end
    endtask

    // One-edge command; optional write in the same accepting cycle
    task automatic op_start(input logic [1:0] c, input logic [4:0] ireg,
                            input bit we, input logic [4:0] wa, input logic [31:0] wd);
        @(negedge clk);
        ctx_cmd = c; ctx_idx_reg = ireg;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk); #1;
        ctx_cmd = 2'b00; wr_en = 1'b0;
    endtask

    // Track the 4 busy cycles; optionally poke ignored stimulus in cycle 1
    task automatic op_track(input string req, input bit poke, input logic [31:0] exp_r9);
        logic [31:0] d;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check(req, {31'b0, busy}, 32'd1);
            check(req, {31'b0, done}, (i == 4) ? 32'd1 : 32'd0);
            if (poke && i == 1) begin
                wr_en = 1'b1; wr_addr = 5'd8; wr_data = 32'hDEAD_DEAD;
                ctx_cmd = 2'b11; pc_in = 32'hFFFF_0000;
            end
            if (poke && i == 2) begin
                wr_en = 1'b0; ctx_cmd = 2'b00;
                read_a(5'd9, d);
                check("R8 read during busy", d, exp_r9);
            end
        end
    endtask

    task automatic check_idle_after(input string req);
        @(negedge clk);
        check(req, {31'b0, busy}, 32'd0);
        check(req, {31'b0, done}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        @(negedge clk);
        check("R11 busy", {31'b0, busy}, 32'd0);
        check("R11 done", {31'b0, done}, 32'd0);
        check("R11 pc_out", pc_out, 32'h0);
        read_a(5'd5, d);  check("R11 r5", d, 32'h0);
        read_a(5'd29, d); check("R11 r29", d, 32'h0);

        // R1 R2 vector table on both read ports
        foreach (VECS[i]) begin
            wr_reg(VECS[i].addr, VECS[i].data);
            rd_addr_a = VECS[i].addr; rd_addr_b = VECS[i].addr; #0.5;
            check("R2/R1 port a", rd_data_a, VECS[i].expv);
            check("R2/R1 port b", rd_data_b, VECS[i].expv);
        end

        // R3 R4 R8: save pattern A to slot 2 (r1 = 6 -> low bits 2)
        fill_ws(32'hA000_0000);
        wr_reg(5'd1, 32'd6);
        wr_reg(5'd5, 32'h5555_0005);
        pc_in = 32'h1111_0040;
        op_start(2'b01, 5'd1, 1'b0, 5'd0, 32'd0);
        pc_in = 32'h2222_0000;
        op_track("R3 save timing", 1'b1, pat(32'hA000_0000, 1));
        check_idle_after("R3 save end");
        // R8: no extra operation was started by the ignored command
        check_idle_after("R8 ignored cmd");
        read_a(5'd8, d); check("R8 write ignored", d, pat(32'hA000_0000, 0));
        check("R8 pc_out untouched", pc_out, 32'h0);

        // R5 R6 R10: scramble, then restore slot 2 while r1 is rewritten in the accept cycle
        fill_ws(32'hB000_0000);
        op_start(2'b11, 5'd1, 1'b1, 5'd1, 32'd3);
        op_track("R6 restore timing", 1'b0, 32'h0);
        check_ws("R5/R10 restored regs", 32'hA000_0000, 1'b0);
        check("R4 saved pc (pc_in at accept)", pc_out, 32'h1111_0040);
        read_a(5'd5, d); check("R5 non-working reg kept", d, 32'h5555_0005);
        read_a(5'd1, d); check("R10 index reg write", d, 32'd3);
        check_idle_after("R6 restore end");

        // R9: restore from never-saved slot 3 (r1 now 3)
        op_start(2'b11, 5'd1, 1'b0, 5'd0, 32'd0);
        op_track("R9 timing", 1'b0, 32'h0);
        check_ws("R9 zero slot", 32'h0, 1'b1);
        check("R9 pc zero", pc_out, 32'h0);
        check_idle_after("R9 end");

        // R7: reserved and idle commands do nothing
        fill_ws(32'hC000_0000);
        op_start(2'b10, 5'd1, 1'b0, 5'd0, 32'd0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 reserved no busy", {31'b0, busy}, 32'd0);
        end
        op_start(2'b00, 5'd1, 1'b0, 5'd0, 32'd0);
        @(negedge clk);
        check("R7 idle no busy", {31'b0, busy}, 32'd0);
        check_ws("R7 regs kept", 32'hC000_0000, 1'b0);

        // R4 second pattern: save C to slot 0, modify, restore
        wr_reg(5'd2, 32'd4);
        pc_in = 32'h0000_ABC0;
        op_start(2'b01, 5'd2, 1'b0, 5'd0, 32'd0);
        op_track("R3 save2", 1'b0, 32'h0);
        check_idle_after("R3 save2 end");
        fill_ws(32'hD000_0000);
        pc_in = 32'h0;
        op_start(2'b11, 5'd2, 1'b0, 5'd0, 32'd0);
        op_track("R6 restore2", 1'b0, 32'h0);
        check_ws("R4 slot0 contents", 32'hC000_0000, 1'b0);
        check("R4 slot0 pc", pc_out, 32'h0000_ABC0);
        read_a(5'd0, d); check("R1 r0 after ops", d, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule